// File: doc/BRIEF.md
# Switching-Cycle Reference Selector

This block decides which clock starts each switching cycle of a two-phase converter controller. It has two possible references. One is a single-cycle tick from the internal oscillator, already in the system clock domain. The other is an asynchronous external sync input. The sync input is first brought into the fast system clock domain through a chain of flops. Its rising edges are then detected there.

Out of reset the internal oscillator is the reference. The first low-to-high transition seen on the synchronized sync level moves the block into external mode. That same edge starts a cycle. While in external mode, only sync rising edges start cycles. If a fixed number of internal ticks pass with no sync rising edge, the block falls back to the internal oscillator. The fallback happens on the tick that completes the count, and that tick itself starts a cycle, so no cycle is cut short.

The block has three outputs. `cycleStart` is a one-clock pulse. `extMode` is the mode flag. `phaseSel` names the phase that owns the cycle being started, and it alternates between phase A and phase B.

Top module: `sync_ref_select`

## Requirements
- R1: While `rstN` is low, and in the first cycle after its release, `extMode`, `cycleStart` and `phaseSel` are all 0.
- R2: In internal mode, when no sync rising edge is detected, `cycleStart` is high for exactly the one clock that follows each clock in which `oscTick` is high, and `extMode` stays 0.
- R3: A 0-to-1 change on `syncIn` is seen after two synchronizer flops. Three rising clock edges after `syncIn` is first sampled high (following a low sample), `extMode` reads 1 and `cycleStart` pulses. A `syncIn` held high with no new low-to-high change never causes entry.
- R4: In external mode, `cycleStart` pulses one clock after each detected sync rising edge. An `oscTick` that does not complete the miss count produces no pulse.
- R5: In external mode, counting every `oscTick` since the last sync rising edge, the 4th such tick (MISS_LIMIT = 4) clears `extMode` and produces a `cycleStart` pulse, both visible one clock after that tick.
- R6: When a sync rising edge and an `oscTick` fall in the same clock in external mode, the edge takes precedence. One pulse is produced, and the miss count restarts from zero.
- R7: `phaseSel` is 0 for phase A and 1 for phase B. It holds its value during each `cycleStart` pulse and inverts in the clock that follows the pulse. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Raw external sync level, asynchronous to `clk` |
| oscTick | input | 1 | One-clock tick from the internal oscillator |
| cycleStart | output | 1 | One-clock pulse marking the start of a switching cycle |
| extMode | output | 1 | 1 when the external sync is the reference |
| phaseSel | output | 1 | Phase of the cycle being started: 0 = A, 1 = B |

## Verification
`cycleStart` and `extMode` each change one rising edge after the clock in which their cause is present. For `oscTick`, the cause is the tick itself. For `syncIn`, the cause is detected only after the synchronizer, so the result is three edges after the input is first sampled high. `phaseSel` moves one edge after a pulse.

The bench drives inputs on falling edges. After each rising edge it steps a cycle model written from these latencies, then compares all three outputs on the next falling edge. The directed cases place sync edges and ticks at those exact offsets:
- entry into external mode;
- a coincident edge and tick;
- the fourth missed tick;
- a level held high after fallback.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;

  typedef struct packed {
    logic fire;
    logic setExt;
    logic clrExt;
  } selStrobe_t;

endpackage

// File: rtl/sync_sel_sync.sv
module sync_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncRise
);

  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncRise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/sync_sel_ctrl.sv
module sync_sel_ctrl
  import sync_sel_pkg::*;
#(
  parameter int MISS_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncRise,
  input  logic       oscTick,
  input  logic       extMode,
  output selStrobe_t strobe
);

  localparam int CW = $clog2(MISS_LIMIT + 1);

  logic [CW-1:0] missCount;
  logic          lastMiss;

  assign lastMiss = (missCount == CW'(MISS_LIMIT - 1));

  always_comb begin
    strobe = '0;
    if (!extMode) begin
      if (syncRise) begin
        strobe.setExt = 1'b1;
        strobe.fire   = 1'b1;
      end else begin
        strobe.fire = oscTick;
      end
    end else if (syncRise) begin
      strobe.fire = 1'b1;
    end else if (oscTick && lastMiss) begin
      strobe.clrExt = 1'b1;
      strobe.fire   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missCount <= '0;
    end else if (!extMode || syncRise || strobe.clrExt) begin
      missCount <= '0;
    end else if (oscTick) begin
      missCount <= missCount + 1'b1;
    end
  end

endmodule

// File: rtl/sync_sel_dp.sv
module sync_sel_dp
  import sync_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  selStrobe_t strobe,
  output logic       extMode,
  output logic       cycleStart,
  output logic       phaseSel
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMode    <= 1'b0;
      cycleStart <= 1'b0;
      phaseSel   <= 1'b0;
    end else begin
      if (strobe.setExt)      extMode <= 1'b1;
      else if (strobe.clrExt) extMode <= 1'b0;
      cycleStart <= strobe.fire;
      phaseSel   <= phaseSel ^ cycleStart;
    end
  end

endmodule

// File: rtl/sync_ref_select.sv
module sync_ref_select
  import sync_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MISS_LIMIT  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic oscTick,
  output logic cycleStart,
  output logic extMode,
  output logic phaseSel
);

  logic       syncRise;
  selStrobe_t strobe;

  sync_sel_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  (syncIn),
    .syncRise (syncRise)
  );

  sync_sel_ctrl #(.MISS_LIMIT(MISS_LIMIT)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncRise (syncRise),
    .oscTick  (oscTick),
    .extMode  (extMode),
    .strobe   (strobe)
  );

  sync_sel_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .extMode    (extMode),
    .cycleStart (cycleStart),
    .phaseSel   (phaseSel)
  );

endmodule

// File: rtl/sync_ref_select_chk.sv
module sync_ref_select_chk #(
  parameter int MISS_LIMIT = 4
) (
  input logic clk,
  input logic rstN,
  input logic syncRise,
  input logic oscTick,
  input logic extMode,
  input logic cycleStart,
  input logic phaseSel
);

  localparam int KW = $clog2(MISS_LIMIT + 2);

  logic [KW-1:0] ckMiss;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    ckMiss <= '0;
    else if (!extMode || syncRise) ckMiss <= '0;
    else if (oscTick)             ckMiss <= ckMiss + 1'b1;
  end

  always_comb begin
    if (!rstN) begin
      a_r1_reset_outputs: assert (!extMode && !cycleStart && !phaseSel);
    end
  end

  a_r2_internal_follow: assert property (@(posedge clk) disable iff (!rstN)
    (!extMode && !syncRise) |=> (!extMode && (cycleStart == $past(oscTick))));

  a_r3_enter_ext: assert property (@(posedge clk) disable iff (!rstN)
    (!extMode && syncRise) |=> (extMode && cycleStart));

  a_r4_edge_starts: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && syncRise) |=> (extMode && cycleStart));

  a_r4_idle_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && !syncRise && !oscTick) |=> (extMode && !cycleStart));

  a_r5_miss_bound: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> (ckMiss < KW'(MISS_LIMIT)));

  a_r5_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && !syncRise && oscTick && ckMiss == KW'(MISS_LIMIT - 1))
      |=> (!extMode && cycleStart));

  a_r7_phase_flip: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> (phaseSel != $past(phaseSel)));

  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> $stable(phaseSel));

endmodule

bind sync_ref_select sync_ref_select_chk #(.MISS_LIMIT(MISS_LIMIT)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .syncRise   (syncRise),
  .oscTick    (oscTick),
  .extMode    (extMode),
  .cycleStart (cycleStart),
  .phaseSel   (phaseSel)
);

// File: tb/sync_ref_select_test.sv
`timescale 1ns/1ps
module sync_ref_select_test;

  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic oscTick = 1'b0;
  logic cycleStart, extMode, phaseSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m1 = 0, m2 = 0, m3 = 0;
  logic mMode = 0, mStart = 0, mPhase = 0;
  int   mCnt = 0;

  always #4 clk = ~clk;

  sync_ref_select #(.SYNC_STAGES(2), .MISS_LIMIT(LIMIT)) uut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .oscTick(oscTick),
    .cycleStart(cycleStart), .extMode(extMode), .phaseSel(phaseSel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic modelStart(input logic rise, input logic tick);
    logic st;
    st = 1'b0;
    if (!mMode) begin
      if (rise) begin mMode = 1'b1; mCnt = 0; st = 1'b1; end
      else st = tick;
    end else if (rise) begin
      mCnt = 0; st = 1'b1;
    end else if (tick) begin
      if (mCnt == LIMIT - 1) begin mMode = 1'b0; mCnt = 0; st = 1'b1; end
      else mCnt = mCnt + 1;
    end
    return st;
  endfunction

  task automatic step(input logic s, input logic t);
    logic rise, st, modeBefore;
    syncIn = s;
    oscTick = t;
    @(posedge clk);
    rise = m2 & ~m3;
    modeBefore = mMode;
    st = modelStart(rise, t);
    mPhase = mPhase ^ mStart;
    mStart = st;
    m3 = m2; m2 = m1; m1 = s;
    @(negedge clk);
    check(modeBefore ? "R4 cycleStart" : "R2 cycleStart", int'(cycleStart), int'(mStart));
    check("R5 extMode", int'(extMode), int'(mMode));
    check("R7 phaseSel", int'(phaseSel), int'(mPhase));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int rnd, halfLeft, burstLeft;
    logic lvl, on;
    rnd = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check("R1 extMode reset", int'(extMode), 0);
    check("R1 cycleStart reset", int'(cycleStart), 0);
    check("R1 phaseSel reset", int'(phaseSel), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 extMode after release", int'(extMode), 0);
    check("R1 phaseSel after release", int'(phaseSel), 0);

    // R2: internal ticks drive cycle starts
    for (int i = 0; i < 12; i++) step(1'b0, (i % 3) == 0);
    step(1'b0, 1'b1);
    check("R2 tick pulse", int'(cycleStart), 1);
    check("R2 mode internal", int'(extMode), 0);
    step(1'b0, 1'b0);
    check("R2 single clock pulse", int'(cycleStart), 0);

    // R3: entry latency of three edges
    step(1'b1, 1'b0);
    check("R3 not yet edge1", int'(extMode), 0);
    step(1'b1, 1'b0);
    check("R3 not yet edge2", int'(extMode), 0);
    step(1'b1, 1'b0);
    check("R3 entered", int'(extMode), 1);
    check("R3 entry pulse", int'(cycleStart), 1);

    // R4: a tick in external mode is not a start
    step(1'b1, 1'b1);
    check("R4 tick ignored", int'(cycleStart), 0);
    check("R4 still external", int'(extMode), 1);

    // R5: fresh edge then four missed ticks
    repeat (4) step(1'b0, 1'b0);
    repeat (4) step(1'b1, 1'b0);
    for (int k = 1; k < LIMIT; k++) begin
      step(1'b1, 1'b1);
      check("R5 holds before limit", int'(extMode), 1);
      check("R5 no pulse before limit", int'(cycleStart), 0);
      step(1'b1, 1'b0);
    end
    step(1'b1, 1'b1);
    check("R5 fallback mode", int'(extMode), 0);
    check("R5 fallback pulse", int'(cycleStart), 1);

    // R3: level stuck high does not re-enter
    repeat (6) step(1'b1, 1'b0);
    check("R3 stuck high no entry", int'(extMode), 0);

    // R6: coincident edge and tick in external mode
    repeat (3) step(1'b0, 1'b0);
    repeat (3) step(1'b1, 1'b0);
    check("R6 setup entered", int'(extMode), 1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    repeat (3) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R6 edge wins pulse", int'(cycleStart), 1);
    check("R6 edge wins mode", int'(extMode), 1);
    for (int k = 1; k < LIMIT; k++) begin
      step(1'b1, 1'b1);
      check("R6 count restarted", int'(extMode), 1);
    end
    step(1'b1, 1'b1);
    check("R6 leaves on fourth", int'(extMode), 0);

    // Random mix of sync bursts, gaps and ticks
    lvl = 1'b1; on = 1'b0; halfLeft = 0; burstLeft = 0;
    for (int c = 0; c < 4000; c++) begin
      if (burstLeft == 0) begin
        on = ($urandom % 4) != 0;
        burstLeft = 20 + int'($urandom % 60);
      end
      burstLeft--;
      if (on) begin
        if (halfLeft == 0) begin
          lvl = ~lvl;
          halfLeft = 2 + int'($urandom % 4);
        end
        halfLeft--;
      end
      step(lvl, ($urandom % 5) == 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule